// File: doc/BRIEF.md
# Entropy Seed Register Access Unit

This unit serves the entropy seed control/status register of a processor core. A request names a CSR address and carries a flag saying whether the instruction writes. It also carries the current privilege level and a flag for virtualized execution. For each request that targets the seed address, the unit decides whether the access is legal. The decision uses the privilege level, the virtualization flag and two enable pins taken from the machine security configuration register: one enable for supervisor mode and one for user mode. A refused access returns a fault code, either illegal instruction or virtual instruction. A permitted access returns a 32-bit word. The top two bits of that word give the health state of the entropy path, and when that state is "entropy ready" the low 16 bits carry a fresh sample.

Samples arrive on a valid/ready stream. The unit holds at most one sample. It raises `ent_ready` only when its holding slot is empty, the power-on self-test window is over and no fatal error has been latched. A sample is taken on a cycle where `ent_valid` and `ent_ready` are both high. The source must hold `ent_valid` and `ent_data` steady until that cycle. While the slot is full, back-pressure is applied until one successful register access consumes the sample. Written data is never stored. The write flag only decides whether the access is legal.

Top module: `seed_csr_unit`

## Requirements
- R1: A request with `req_valid` high and `req_addr` equal to 0x015 produces `rsp_valid` high on the next cycle. A request to any other address produces no response.
- R2: A request whose `req_write` is low returns fault code 01 (illegal instruction), whatever the privilege. This check takes priority over every other rule.
- R3: With `req_write` high and privilege 3 (machine), the access is always permitted and returns fault code 00.
- R4: Outside virtualized execution, the privilege encoding is 0 = user, 1 = supervisor, 3 = machine. Privilege 1 is permitted only when `cfg_sseed` is high. Privilege 0 is permitted only when `cfg_useed` is high. Privilege 2 is always refused. Every refusal returns code 01.
- R5: When `req_virt` is high and the privilege is below machine, a writing access returns code 10 (virtual instruction) if `cfg_sseed` is high, and code 01 otherwise.
- R6: On a permitted access, bits 31:30 hold the state: 00 self-test, 01 waiting, 10 entropy ready, 11 dead. Bits 29:16 read zero. Bits 15:0 hold the buffered sample only when the state is 10, and zero otherwise.
- R7: For the first BIST_CYCLES cycles after reset, the state is 00 and `ent_ready` stays low.
- R8: Exactly one permitted access consumes a buffered sample. After that the state reads 01 until a new sample has been accepted. `ent_ready` is high only while the slot is empty.
- R9: A faulting access returns a data word of zero and leaves any buffered sample in place.
- R10: A high `fatal_err` moves the state to 11 from the next cycle. The state stays at 11 and `ent_ready` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | CSR access request present |
| req_addr | input | 12 | CSR address of the access |
| req_write | input | 1 | Instruction performs a write |
| req_priv | input | 2 | Privilege level (0 user, 1 supervisor, 3 machine) |
| req_virt | input | 1 | Hart is executing virtualized |
| cfg_useed | input | 1 | Security configuration: user-mode seed enable |
| cfg_sseed | input | 1 | Security configuration: supervisor-mode seed enable |
| fatal_err | input | 1 | Fatal health failure from the entropy source |
| ent_valid | input | 1 | Entropy sample offered |
| ent_ready | output | 1 | Unit can accept a sample |
| ent_data | input | 16 | Entropy sample |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Status word with optional sample |
| rsp_fault | output | 2 | 00 none, 01 illegal instruction, 10 virtual instruction |

## Verification
Every response is registered and appears one cycle after its request. The bench drives each request just after a falling edge and computes the expected word from its own model state as it stood before the next rising edge. It then samples the response at the following falling edge. `ent_ready`, the self-test window, consumption and the dead state each move on the rising edge where their cause is sampled. The bench therefore updates its model at that same edge and compares `ent_ready` at the next falling edge, before it drives new inputs.

// File: rtl/seed_pkg.sv
package seed_pkg;
  localparam int WORD_W   = 32;
  localparam int SAMPLE_W = 16;
  localparam int PRIV_W   = 2;

  typedef enum logic [1:0] {
    OPS_SELFTEST = 2'b00,
    OPS_PENDING  = 2'b01,
    OPS_READY    = 2'b10,
    OPS_FAILED   = 2'b11
  } opstate_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_ILLEGAL = 2'b01,
    FLT_VIRTUAL = 2'b10
  } fault_e;

  localparam logic [PRIV_W-1:0] PRIV_USER    = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_SUPER   = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'd3;
endpackage

// File: rtl/seed_access_check.sv
module seed_access_check
  import seed_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] SEED_ADDR = 12'h015,
  parameter bit          HAS_HYP   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write_en,
  input  logic [PRIV_W-1:0] priv,
  input  logic              virt,
  input  logic              useed,
  input  logic              sseed,
  output logic              hit,
  output fault_e            fault
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SEED_ADDR);

  logic virt_eff;

  generate
    if (HAS_HYP) begin : g_hyp
      assign virt_eff = virt && (priv != PRIV_MACHINE);
    end else begin : g_nohyp
      logic unused_virt;
      assign unused_virt = virt;
      assign virt_eff    = 1'b0;
    end
  endgenerate

  assign hit = (addr == MATCH);

  always_comb begin
    if (!write_en) begin
      fault = FLT_ILLEGAL;
    end else if (priv == PRIV_MACHINE) begin
      fault = FLT_NONE;
    end else if (virt_eff) begin
      fault = sseed ? FLT_VIRTUAL : FLT_ILLEGAL;
    end else if (priv == PRIV_SUPER) begin
      fault = sseed ? FLT_NONE : FLT_ILLEGAL;
    end else if (priv == PRIV_USER) begin
      fault = useed ? FLT_NONE : FLT_ILLEGAL;
    end else begin
      fault = FLT_ILLEGAL;
    end
  end
endmodule

// File: rtl/seed_health.sv
module seed_health #(
  parameter int BIST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fatal_in,
  output logic bist_done,
  output logic dead
);
  localparam int              CNT_W   = $clog2(BIST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BIST_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             dead_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_END) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dead_q <= 1'b0;
    end else if (fatal_in) begin
      dead_q <= 1'b1;
    end
  end

  assign bist_done = (cnt_q == CNT_END);
  assign dead      = dead_q;

  p_dead_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> dead);
  p_fatal_kills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_in |=> dead);
  p_bist_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bist_done |=> bist_done);
endmodule

// File: rtl/seed_sample_buf.sv
module seed_sample_buf #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                flush,
  input  logic                consume,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                full,
  output logic [SAMPLE_W-1:0] data
);
  logic                full_q;
  logic [SAMPLE_W-1:0] data_q;
  logic                take;

  assign in_ready = enable && !full_q;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (flush) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (consume) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

  p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);
  p_consume_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !full);
  p_hold_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !consume && !flush) |=> (full && $stable(data)));
endmodule

// File: rtl/seed_csr_unit.sv
module seed_csr_unit
  import seed_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] SEED_ADDR   = 12'h015,
  parameter bit          HAS_HYP     = 1'b1,
  parameter int          BIST_CYCLES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [PRIV_W-1:0]   req_priv,
  input  logic                req_virt,
  input  logic                cfg_useed,
  input  logic                cfg_sseed,
  input  logic                fatal_err,
  input  logic                ent_valid,
  output logic                ent_ready,
  input  logic [SAMPLE_W-1:0] ent_data,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_data,
  output logic [1:0]          rsp_fault
);
  localparam int                PAD_W = WORD_W - 2 - SAMPLE_W;
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SEED_ADDR);

  logic                hit;
  fault_e              fault;
  logic                bist_done;
  logic                dead;
  logic                buf_full;
  logic [SAMPLE_W-1:0] buf_data;
  opstate_e            state;
  logic                granted;
  logic                consume;

  seed_access_check #(
    .ADDR_W(ADDR_W), .SEED_ADDR(SEED_ADDR), .HAS_HYP(HAS_HYP)
  ) u_check (
    .addr(req_addr), .write_en(req_write), .priv(req_priv), .virt(req_virt),
    .useed(cfg_useed), .sseed(cfg_sseed), .hit(hit), .fault(fault)
  );

  seed_health #(.BIST_CYCLES(BIST_CYCLES)) u_health (
    .clk(clk), .rst_n(rst_n), .fatal_in(fatal_err),
    .bist_done(bist_done), .dead(dead)
  );

  seed_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .enable(bist_done && !dead), .flush(dead),
    .consume(consume), .in_valid(ent_valid), .in_ready(ent_ready),
    .in_data(ent_data), .full(buf_full), .data(buf_data)
  );

  always_comb begin
    if (dead)            state = OPS_FAILED;
    else if (!bist_done) state = OPS_SELFTEST;
    else if (buf_full)   state = OPS_READY;
    else                 state = OPS_PENDING;
  end

  assign granted = req_valid && hit && (fault == FLT_NONE);
  assign consume = granted && (state == OPS_READY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid && hit;
      rsp_fault <= (req_valid && hit) ? fault : FLT_NONE;
      if (granted) begin
        rsp_data <= {state, {PAD_W{1'b0}},
                     (state == OPS_READY) ? buf_data : {SAMPLE_W{1'b0}}};
      end else begin
        rsp_data <= '0;
      end
    end
  end

  p_resp_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == MATCH) |=> rsp_valid);
  p_miss_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_addr == MATCH) |=> !rsp_valid);
  p_nowrite_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == MATCH && !req_write) |=> rsp_fault == 2'b01);
  p_machine_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == MATCH && req_write && req_priv == PRIV_MACHINE)
      |=> rsp_fault == 2'b00);
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_data[29:16] == '0);
  p_sample_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_data[31:30] != 2'b10) |-> rsp_data[15:0] == '0);
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_data == '0);
endmodule

// File: tb/tb_seed_csr_unit.sv
`timescale 1ns/1ps
module tb_seed_csr_unit;
  localparam int BIST = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_virt, cfg_useed, cfg_sseed;
  logic        fatal_err, ent_valid, ent_ready, rsp_valid;
  logic [11:0] req_addr;
  logic [1:0]  req_priv, rsp_fault;
  logic [15:0] ent_data;
  logic [31:0] rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model
  bit          m_full, m_dead;
  logic [15:0] m_data;
  int          m_cnt;

  always #4 clk = ~clk;

  seed_csr_unit #(.BIST_CYCLES(BIST)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_priv(req_priv), .req_virt(req_virt),
    .cfg_useed(cfg_useed), .cfg_sseed(cfg_sseed), .fatal_err(fatal_err),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_data(ent_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(bit w, logic [1:0] p, bit vt,
                                           bit us, bit ss);
    if (!w) return 2'b01;
    if (p == 2'd3) return 2'b00;
    if (vt) return ss ? 2'b10 : 2'b01;
    if (p == 2'd1) return ss ? 2'b00 : 2'b01;
    if (p == 2'd0) return us ? 2'b00 : 2'b01;
    return 2'b01;
  endfunction

  function automatic string fault_tag(bit w, logic [1:0] p, bit vt);
    if (!w) return "R2";
    if (p == 2'd3) return "R3";
    if (vt) return "R5";
    return "R4";
  endfunction

  function automatic logic [1:0] model_state();
    if (m_dead) return 2'b11;
    if (m_cnt < BIST) return 2'b00;
    return m_full ? 2'b10 : 2'b01;
  endfunction

  // Called just after a falling edge; returns just after the next one.
  task automatic step(input bit v, input logic [11:0] a, input bit w,
                      input logic [1:0] p, input bit vt, input bit us,
                      input bit ss, input bit fe, input bit ev,
                      input logic [15:0] ed);
    logic [1:0]  st, f;
    logic [31:0] exp_d;
    bit hitm, rdy, acc, cons;
    string rtag;
    req_valid = v; req_addr = a; req_write = w; req_priv = p; req_virt = vt;
    cfg_useed = us; cfg_sseed = ss; fatal_err = fe; ent_valid = ev;
    ent_data = ed;
    st   = model_state();
    hitm = v && (a == 12'h015);
    f    = exp_fault(w, p, vt, us, ss);
    rdy  = (m_cnt >= BIST) && !m_full && !m_dead;
    rtag = m_dead ? "R10" : (m_cnt < BIST) ? "R7" : "R8";
    #1;
    chk(ent_ready == rdy, rtag, "ent_ready", {31'b0, ent_ready}, {31'b0, rdy});
    exp_d = (hitm && f == 2'b00) ?
            {st, 14'b0, (st == 2'b10) ? m_data : 16'h0} : 32'h0;
    acc  = ev && rdy;
    cons = hitm && (f == 2'b00) && (st == 2'b10);
    @(posedge clk);
    if (m_dead) m_full = 1'b0;
    else if (cons) m_full = 1'b0;
    else if (acc) begin m_full = 1'b1; m_data = ed; end
    if (fe) m_dead = 1'b1;
    if (m_cnt < BIST) m_cnt++;
    @(negedge clk);
    chk(rsp_valid == hitm, "R1", "rsp_valid", {31'b0, rsp_valid}, {31'b0, hitm});
    if (hitm) begin
      chk(rsp_fault == f, fault_tag(w, p, vt), "rsp_fault",
          {30'b0, rsp_fault}, {30'b0, f});
      if (f != 2'b00)
        chk(rsp_data == exp_d, "R9", "faulting data", rsp_data, exp_d);
      else if (st == 2'b00)
        chk(rsp_data == exp_d, "R7", "selftest word", rsp_data, exp_d);
      else if (st == 2'b11)
        chk(rsp_data == exp_d, "R10", "dead word", rsp_data, exp_d);
      else if (st == 2'b01)
        chk(rsp_data == exp_d, "R8", "waiting word", rsp_data, exp_d);
      else
        chk(rsp_data == exp_d, "R6", "ready word", rsp_data, exp_d);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(0, 12'h0, 0, 2'd0, 0, 0, 0, 0, 0, 16'h0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; req_valid = 0; req_addr = 0; req_write = 0; req_priv = 0;
    req_virt = 0; cfg_useed = 0; cfg_sseed = 0; fatal_err = 0;
    ent_valid = 0; ent_data = 0;
    m_full = 0; m_dead = 0; m_data = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk(ent_ready == 1'b0, "R7", "reset ent_ready", {31'b0, ent_ready}, 32'h0);
    rst_n = 1'b1;

    // R7: access during self-test reports state 00, sample offered is refused
    step(1, 12'h015, 1, 2'd3, 0, 0, 0, 0, 1, 16'h1111);
    idle(BIST);

    // R8: accept, consume once, then waiting
    step(0, 12'h0, 0, 2'd0, 0, 0, 0, 0, 1, 16'hBEEF);
    step(1, 12'h015, 1, 2'd3, 0, 0, 0, 0, 0, 16'h0);
    step(1, 12'h015, 1, 2'd3, 0, 0, 0, 0, 0, 16'h0);
    chk(rsp_data[31:30] == 2'b01, "R8", "second read waits",
        {30'b0, rsp_data[31:30]}, 32'h1);

    // R2 and R9: read-only access faults, sample survives
    step(0, 12'h0, 0, 2'd0, 0, 0, 0, 0, 1, 16'h1234);
    step(1, 12'h015, 0, 2'd3, 0, 1, 1, 0, 0, 16'h0);
    step(1, 12'h015, 1, 2'd1, 0, 0, 0, 0, 0, 16'h0);  // R4 refused
    step(1, 12'h015, 1, 2'd1, 1, 0, 1, 0, 0, 16'h0);  // R5 virtual fault
    step(1, 12'h015, 1, 2'd0, 1, 1, 0, 0, 0, 16'h0);  // R5 illegal
    step(1, 12'h015, 1, 2'd2, 0, 1, 1, 0, 0, 16'h0);  // R4 reserved priv
    step(1, 12'h016, 1, 2'd3, 0, 1, 1, 0, 0, 16'h0);  // R1 other address
    step(1, 12'h015, 1, 2'd0, 0, 1, 0, 0, 0, 16'h0);  // R4 user ok, R6 data
    chk(rsp_data == 32'h8000_1234, "R9", "sample kept across faults",
        rsp_data, 32'h8000_1234);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      a = ($urandom % 4 != 0) ? 12'h015 : 12'($urandom);
      step($urandom % 2, a, ($urandom % 5) != 0, 2'($urandom),
           ($urandom % 4) == 0, $urandom % 2, $urandom % 2, 0,
           $urandom % 2, 16'($urandom));
    end

    // R10: fatal error makes the state dead and sticky
    step(0, 12'h0, 0, 2'd0, 0, 0, 0, 1, 1, 16'h5555);
    for (int i = 0; i < 6; i++)
      step(1, 12'h015, 1, 2'd3, 0, 0, 0, 0, 1, 16'h7777);
    chk(rsp_data == 32'hC000_0000, "R10", "dead word", rsp_data, 32'hC000_0000);

    done = 1'b1;
    report();
  end
endmodule